// File: doc/BRIEF.md
# Remote framebuffer bus interface

This block sits between a 32-bit register port and a 16-bit parallel bus that drives up to two external display controllers. Each controller has its own chip select. Software selects one or both controllers through the control register. It then writes commands, parameters and pixel data, or triggers 16-bit reads, and the block turns each register access into one or two single-cycle bus strobes. Every bus word carries a flag that marks it as a command or as data/parameter.

A transfer window is opened by setting the start bit in the control register, provided the block is enabled, not in bypass and not already busy. A pixel down-counter, loaded through its own register, is decremented by every data write and every read trigger. When it reaches zero while busy, the busy flag drops and a one-cycle frame-done pulse goes out toward the interrupt logic. Timing and data-cycle registers for the two controllers are kept and read back only; they do not shape the bus cycles.

Top module: `rfb_ctrl`

## Requirements
- R1: After reset the control register reads 0x2, both config registers (0x28 and 0x40) read 0x00310000, the status register (0x04) reads 0x1, and the pixel counter (0x0C) and receive buffer (0x20) read 0.
- R2: Stored registers keep only their valid bits. Config keeps 0x003f1fff, on/off timing keeps 0x3fffffff, cycle timing keeps 0x0fffffff, data-cycle keeps 0x0f1f0f1f, vsync/hsync keep 16 bits, line number keeps 11 bits, idle mode keeps 0x19 and control keeps 4 bits.
- R3: The write strobe routes to control bit 2 (chip 0, bus_cs[0]) and control bit 3 (chip 1, bus_cs[1]) together. With neither bit set, no strobe is issued.
- R4: A write to the command register (0x14) drives the low 16 bits with bus_cmd=1. A write to the parameter register (0x18) drives them with bus_cmd=0. Either strobe comes one cycle after the write is accepted.
- R5: A write to the data register (0x1C) issues two strobes in consecutive cycles with bus_cmd=0, the low half first and then the high half. reg_ready is low during the first strobe, and a request is not taken while reg_ready is low.
- R6: Writing 0x20 (read data, bus_cmd=0) or 0x24 (read status, bus_cmd=1) issues one read strobe to a single chip, chip 0 in preference to chip 1. bus_din is captured into the receive buffer, which reads back at 0x20 and at 0x24.
- R7: Data writes and read triggers decrement the pixel counter even when no chip is selected, and the count wraps from 0 to all ones.
- R8: Writing control with bit 4 set starts a transfer only if the new bit 0 is 1 and the new bit 1 is 0, the block is not busy, and config 0 and config 1 share no set bit in bits 3:2. A start with a nonzero count sets busy, which reads as status bit 8.
- R9: When a decrement brings the counter to zero while busy, busy clears and frame_done pulses for one cycle, in the cycle after the write is accepted. A start with a zero count pulses frame_done without setting busy.
- R10: Writing the sysconfig register (0x00) with bit 1 set returns every register to its reset value and then stores the written idle bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write request, held until accepted |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| reg_ready | output | 1 | High when a request can be accepted |
| bus_wr_stb | output | 1 | Single-cycle bus write strobe |
| bus_rd_stb | output | 1 | Single-cycle bus read strobe |
| bus_cs | output | 2 | Chip-select vector for the current strobe |
| bus_cmd | output | 1 | 1 = command/status word, 0 = data/parameter word |
| bus_dout | output | 16 | Bus write data |
| bus_din | input | 16 | Bus read data, valid during bus_rd_stb |
| frame_done | output | 1 | One-cycle transfer-completion pulse |

## Verification
A wrong pixel count or busy state shows at the ports in two ways. frame_done comes early, late or not at all, and the count or busy flag read back through the registers differs on the very next access. A corrupted pending half-word or chip-select vector shows on the bus one or two cycles after the offending write. Random traffic with small pixel counts forces many completions, starts and refused starts. Directed cases cover the wrap, the start gate, bypass and soft reset.

// File: rtl/rfb_ctrl.sv
`timescale 1ns/1ps
module rfb_ctrl #(
  parameter int ADDR_W = 8,
  parameter int PIX_W  = 32,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_ready,
  output logic              bus_wr_stb,
  output logic              bus_rd_stb,
  output logic [1:0]        bus_cs,
  output logic              bus_cmd,
  output logic [15:0]       bus_dout,
  input  logic [15:0]       bus_din,
  output logic              frame_done
);

  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_PIX  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_PAR  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_RDD  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_RDS  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_VS   = ADDR_W'('h58);
  localparam logic [ADDR_W-1:0] A_HS   = ADDR_W'('h5C);
  localparam int NBANK = 2;
  localparam int NDCY  = 3;

  logic [4:0]        idle_q;
  logic [3:0]        ctrl_q;
  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;
  logic [15:0]       rx_q, vs_q, hs_q, hi_q;
  logic              busy_q, hi_pend, rd_pend;

  logic [NBANK-1:0][31:0] bank_rd;
  logic [NBANK-1:0][1:0]  bank_mode;

  wire wr_acc   = reg_wr && reg_ready;
  wire soft_rst = wr_acc && reg_addr == A_SYS && reg_wdata[1];
  wire [1:0] wcs = ctrl_q[3:2];
  wire [1:0] rcs = ctrl_q[2] ? 2'b01 : (ctrl_q[3] ? 2'b10 : 2'b00);
  wire is_dec   = wr_acc && (reg_addr == A_DATA || reg_addr == A_RDD || reg_addr == A_RDS);
  wire [PIX_W-1:0] pix_nx = pix_q - PIX_W'(1);
  wire cfg_ok   = (bank_mode[0] & bank_mode[1]) == 2'b00;
  wire go_ok    = reg_wdata[4] && reg_wdata[0] && !reg_wdata[1] && !busy_q && cfg_ok;

  assign reg_ready = !(hi_pend || rd_pend);

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(b == 0 ? 'h28 : 'h40);
      logic [31:0] cfg_q, onoff_q, cyc_q, rd_v;
      logic [NDCY-1:0][31:0] dcy_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q <= 32'h0031_0000; onoff_q <= '0; cyc_q <= '0; dcy_q <= '0;
        end else if (soft_rst) begin
          cfg_q <= 32'h0031_0000; onoff_q <= '0; cyc_q <= '0; dcy_q <= '0;
        end else if (wr_acc) begin
          if (reg_addr == BASE)                 cfg_q   <= reg_wdata & 32'h003f_1fff;
          if (reg_addr == BASE + ADDR_W'(4))    onoff_q <= reg_wdata & 32'h3fff_ffff;
          if (reg_addr == BASE + ADDR_W'(8))    cyc_q   <= reg_wdata & 32'h0fff_ffff;
          for (int k = 0; k < NDCY; k++)
            if (reg_addr == BASE + ADDR_W'(12 + 4 * k)) dcy_q[k] <= reg_wdata & 32'h0f1f_0f1f;
        end
      end

      always_comb begin
        rd_v = '0;
        if (reg_addr == BASE)              rd_v = cfg_q;
        if (reg_addr == BASE + ADDR_W'(4)) rd_v = onoff_q;
        if (reg_addr == BASE + ADDR_W'(8)) rd_v = cyc_q;
        for (int k = 0; k < NDCY; k++)
          if (reg_addr == BASE + ADDR_W'(12 + 4 * k)) rd_v = dcy_q[k];
      end

      assign bank_rd[b]   = rd_v;
      assign bank_mode[b] = cfg_q[3:2];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0; ctrl_q <= 4'h2; pix_q <= '0; line_q <= '0;
      rx_q <= '0; vs_q <= '0; hs_q <= '0; hi_q <= '0;
      busy_q <= 1'b0; hi_pend <= 1'b0; rd_pend <= 1'b0;
      bus_wr_stb <= 1'b0; bus_rd_stb <= 1'b0; bus_cs <= '0; bus_cmd <= 1'b0;
      bus_dout <= '0; frame_done <= 1'b0;
    end else begin
      bus_wr_stb <= 1'b0;
      bus_rd_stb <= 1'b0;
      frame_done <= 1'b0;
      if (hi_pend) begin
        bus_wr_stb <= 1'b1;
        bus_dout   <= hi_q;
        hi_pend    <= 1'b0;
      end
      if (rd_pend) begin
        rx_q    <= bus_din;
        rd_pend <= 1'b0;
      end
      if (soft_rst) begin
        idle_q <= reg_wdata[4:0] & 5'h19; ctrl_q <= 4'h2; pix_q <= '0; line_q <= '0;
        rx_q <= '0; vs_q <= '0; hs_q <= '0; busy_q <= 1'b0;
      end else if (wr_acc) begin
        case (reg_addr)
          A_SYS:  idle_q <= reg_wdata[4:0] & 5'h19;
          A_CTRL: begin
            ctrl_q <= reg_wdata[3:0];
            if (go_ok) begin
              if (pix_q == '0) frame_done <= 1'b1;
              else             busy_q     <= 1'b1;
            end
          end
          A_PIX:  pix_q  <= reg_wdata[PIX_W-1:0];
          A_LINE: line_q <= reg_wdata[LINE_W-1:0];
          A_VS:   vs_q   <= reg_wdata[15:0];
          A_HS:   hs_q   <= reg_wdata[15:0];
          A_CMD, A_PAR, A_DATA: if (wcs != 2'b00) begin
            bus_wr_stb <= 1'b1;
            bus_cs     <= wcs;
            bus_cmd    <= reg_addr == A_CMD;
            bus_dout   <= reg_wdata[15:0];
            if (reg_addr == A_DATA) begin
              hi_q    <= reg_wdata[31:16];
              hi_pend <= 1'b1;
            end
          end
          A_RDD, A_RDS: if (rcs != 2'b00) begin
            bus_rd_stb <= 1'b1;
            bus_cs     <= rcs;
            bus_cmd    <= reg_addr == A_RDS;
            rd_pend    <= 1'b1;
          end
          default: ;
        endcase
        if (is_dec) begin
          pix_q <= pix_nx;
          if (busy_q && pix_nx == '0) begin
            busy_q     <= 1'b0;
            frame_done <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_SYS:        reg_rdata = {27'd0, idle_q};
      A_STAT:       reg_rdata = {23'd0, busy_q, 8'h01};
      A_CTRL:       reg_rdata = {28'd0, ctrl_q};
      A_PIX:        reg_rdata = 32'(pix_q);
      A_LINE:       reg_rdata = 32'(line_q);
      A_RDD, A_RDS: reg_rdata = {16'd0, rx_q};
      A_VS:         reg_rdata = {16'd0, vs_q};
      A_HS:         reg_rdata = {16'd0, hs_q};
      default:      reg_rdata = bank_rd[0] | bank_rd[1];
    endcase
  end

endmodule

// File: rtl/rfb_ctrl_chk.sv
`timescale 1ns/1ps
module rfb_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_ready,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              bus_wr_stb,
  input logic              bus_rd_stb,
  input logic [1:0]        bus_cs,
  input logic              bus_cmd,
  input logic [15:0]       bus_dout,
  input logic              frame_done,
  input logic              busy_q,
  input logic [3:0]        ctrl_q
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'('h1C);

  wire data_acc = reg_wr && reg_ready && reg_addr == A_DATA && ctrl_q[3:2] != 2'b00;

  assert_wr_has_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_stb |-> bus_cs != 2'b00);
  assert_rd_one_chip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_stb |-> $countones(bus_cs) == 1);
  assert_no_dual_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_stb && bus_rd_stb));
  assert_data_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> bus_wr_stb && !bus_cmd && bus_dout == $past(reg_wdata[15:0]) && !reg_ready);
  assert_data_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> ##1 bus_wr_stb && !bus_cmd && bus_dout == $past(reg_wdata[31:16], 2));
  assert_stall_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_ready |=> reg_ready);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy_q);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_status_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_STAT |-> reg_rdata[0]);
endmodule

bind rfb_ctrl rfb_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rfb_ctrl_test.sv
`timescale 1ns/1ps
module rfb_ctrl_test;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic reg_ready, bus_wr_stb, bus_rd_stb, bus_cmd, frame_done;
  logic [1:0] bus_cs;
  logic [15:0] bus_dout, bus_din;
  logic [6:0] salt = 0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] din_fn(logic [1:0] cs, logic cmd, logic [6:0] s);
    return {4'hA, 2'b00, cmd, cs, s};
  endfunction
  assign bus_din = din_fn(bus_cs, bus_cmd, salt);

  rfb_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .bus_wr_stb(bus_wr_stb), .bus_rd_stb(bus_rd_stb), .bus_cs(bus_cs), .bus_cmd(bus_cmd),
    .bus_dout(bus_dout), .bus_din(bus_din), .frame_done(frame_done));

  logic [3:0] m_ctrl; logic [31:0] m_pix, m_cfg0, m_cfg1; logic m_busy; logic [15:0] m_rx;

  task automatic m_reset();
    m_ctrl = 4'h2; m_pix = 0; m_cfg0 = 32'h0031_0000; m_cfg1 = 32'h0031_0000;
    m_busy = 0; m_rx = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic op(logic [7:0] a, logic [31:0] d);
    logic [1:0] wcs, rcs; logic exp_fd; logic [31:0] nx; logic two;
    wcs = m_ctrl[3:2];
    rcs = m_ctrl[2] ? 2'b01 : (m_ctrl[3] ? 2'b10 : 2'b00);
    exp_fd = 0; two = 0;
    salt = 7'($urandom);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #0.5;
    @(negedge clk); reg_wr = 0;
    case (a)
      8'h14, 8'h18, 8'h1C: begin
        chk("R3 write strobe", 32'(bus_wr_stb), 32'(wcs != 0));
        chk("R3 bus_rd_stb idle", 32'(bus_rd_stb), 0);
        if (wcs != 0) begin
          chk("R3 write chip select", 32'(bus_cs), 32'(wcs));
          chk("R4 cmd flag", 32'(bus_cmd), 32'(a == 8'h14));
          chk("R4 low half", 32'(bus_dout), 32'(d[15:0]));
          two = (a == 8'h1C);
        end
      end
      8'h20, 8'h24: begin
        chk("R6 read strobe", 32'(bus_rd_stb), 32'(rcs != 0));
        chk("R6 no write strobe", 32'(bus_wr_stb), 0);
        if (rcs != 0) begin
          chk("R6 read chip preference", 32'(bus_cs), 32'(rcs));
          chk("R6 read flag", 32'(bus_cmd), 32'(a == 8'h24));
          m_rx = din_fn(rcs, a == 8'h24, salt);
          two = 1;
        end
      end
      8'h08: begin
        m_ctrl = d[3:0];
        if (d[4] && d[0] && !d[1] && !m_busy && ((m_cfg0 & m_cfg1 & 32'hc) == 0)) begin
          if (m_pix == 0) exp_fd = 1; else m_busy = 1;
        end
      end
      8'h0C: m_pix = d;
      8'h28: m_cfg0 = d & 32'h003f_1fff;
      8'h40: m_cfg1 = d & 32'h003f_1fff;
      8'h00: if (d[1]) m_reset();
      default: ;
    endcase
    if (a == 8'h1C || a == 8'h20 || a == 8'h24) begin
      nx = m_pix - 1;
      if (m_busy && nx == 0) begin m_busy = 0; exp_fd = 1; end
      m_pix = nx;
    end
    chk("R9 frame_done", 32'(frame_done), 32'(exp_fd));
    chk("R5 ready during strobe", 32'(reg_ready), 32'(!two));
    if (two) begin
      @(negedge clk);
      chk("R9 frame_done single", 32'(frame_done), 0);
      chk("R5 ready back", 32'(reg_ready), 1);
      if (a == 8'h1C) begin
        chk("R5 high strobe", 32'(bus_wr_stb), 1);
        chk("R5 high half", 32'(bus_dout), 32'(d[31:16]));
        chk("R5 high cs", 32'(bus_cs), 32'(wcs));
        chk("R5 high flag", 32'(bus_cmd), 0);
      end else begin
        chk("R6 single read strobe", 32'(bus_rd_stb), 0);
      end
    end
  endtask

  task automatic state_chk();
    rd_chk(8'h04, {23'd0, m_busy, 8'h01}, "R8 status busy bit");
    rd_chk(8'h0C, m_pix, "R7 pixel count");
    rd_chk(8'h20, {16'd0, m_rx}, "R6 receive buffer");
    rd_chk(8'h08, {28'd0, m_ctrl}, "R8 control");
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk(8'h08, 32'h2, "R1 control reset");
    rd_chk(8'h28, 32'h0031_0000, "R1 config0 reset");
    rd_chk(8'h40, 32'h0031_0000, "R1 config1 reset");
    rd_chk(8'h04, 32'h1, "R1 status reset");
    rd_chk(8'h0C, 32'h0, "R1 pixel reset");
    rd_chk(8'h20, 32'h0, "R1 rx reset");
    // R2 masks
    op(8'h28, '1); rd_chk(8'h28, 32'h003f_1fff, "R2 config mask");
    op(8'h2C, '1); rd_chk(8'h2C, 32'h3fff_ffff, "R2 on/off mask");
    op(8'h48, '1); rd_chk(8'h48, 32'h0fff_ffff, "R2 cycle mask");
    op(8'h50, '1); rd_chk(8'h50, 32'h0f1f_0f1f, "R2 data-cycle mask");
    op(8'h58, '1); rd_chk(8'h58, 32'h0000_ffff, "R2 vsync width");
    op(8'h10, '1); rd_chk(8'h10, 32'h0000_07ff, "R2 line mask");
    op(8'h00, 32'hffff_fffd); rd_chk(8'h00, 32'h19, "R2 idle mask");
    op(8'h08, 32'hffff_ffe0); rd_chk(8'h08, 32'h0, "R2 control mask");
    op(8'h28, 32'h0031_0000);
    // R3 no chip selected: no strobe, count still moves (R7 wrap)
    op(8'h14, 32'h1111_2222);
    op(8'h1C, 32'hAAAA_5555);
    rd_chk(8'h0C, 32'hffff_ffff, "R7 wrap from zero");
    // R6 both chips selected reads chip 0
    op(8'h08, 32'h0c); op(8'h24, 0); op(8'h20, 0); state_chk();
    op(8'h1C, 32'hdead_beef); op(8'h18, 32'h0000_0042);
    // R8 start gated by config overlap
    op(8'h0C, 2); op(8'h28, 32'h4); op(8'h40, 32'h4);
    op(8'h08, 32'h1d); rd_chk(8'h04, 32'h1, "R8 start refused by config");
    op(8'h40, 32'h8); op(8'h08, 32'h1d); rd_chk(8'h04, 32'h101, "R8 start taken");
    op(8'h1C, 32'h0102_0304); op(8'h1C, 32'h0506_0708);
    rd_chk(8'h04, 32'h1, "R9 busy cleared at zero");
    // R8 bypass blocks start; R9 zero-count start
    op(8'h0C, 3); op(8'h08, 32'h1f); rd_chk(8'h04, 32'h1, "R8 bypass blocks start");
    op(8'h0C, 0); op(8'h08, 32'h15);
    // R10 soft reset
    op(8'h0C, 5); op(8'h08, 32'h15); op(8'h00, 32'h1b);
    rd_chk(8'h00, 32'h19, "R10 idle after soft reset");
    rd_chk(8'h28, 32'h0031_0000, "R10 config restored");
    state_chk();
    // random traffic
    for (int i = 0; i < 600; i++) begin
      int sel; logic [31:0] v;
      sel = $urandom_range(0, 9);
      v = $urandom;
      case (sel)
        0: op(8'h14, v);
        1: op(8'h18, v);
        2, 3: op(8'h1C, v);
        4: op(8'h20, v);
        5: op(8'h24, v);
        6: op(8'h08, {27'd0, v[4], v[3:2], ($urandom_range(0, 7) == 0), v[0] | v[5]});
        7: op(8'h0C, 32'($urandom_range(0, 3)));
        8: op(($urandom_range(0, 1) == 0) ? 8'h28 : 8'h40, v & 32'h0031_000c);
        default: state_chk();
      endcase
    end
    state_chk();
    summary();
  end
endmodule